// File: doc/BRIEF.md
# Frame-Reseeded Bit-Serial Scrambler

This block whitens a serial payload stream. Each accepted data bit is XORed with one bit of a pseudo-noise sequence. A 10-bit shift register with linear feedback produces that sequence. The register returns to an all-ones seed whenever a frame begins, so every frame starts with the same sequence.

The operation is its own inverse. A second copy of the block, placed on the receive side and fed the same frame boundaries, recovers the original bits. Data moves one bit per cycle under a valid flag. The output is registered and appears one cycle after the input.

Top module: `frame_scrambler`

## Requirements
- R1: After reset `out_valid` and `out_bit` are 0. The shift register starts at the all-ones seed, so the first valid bit after reset uses the same sequence bit as the first bit of a frame.
- R2: One cycle after a cycle with `in_valid` high, `out_bit` equals that cycle's `in_bit` XOR the current sequence bit. `out_bit` is 0 whenever `out_valid` is 0.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock.
- R4: The sequence bit is the XOR of register stages 10 and 3, counting stages 1 to 10 from the input end. Stage 1 is bit 0 and stage 10 is bit 9. The same bit is shifted into stage 1 while the older stages move one place toward stage 10.
- R5: A `frame_start` pulse reloads every stage of the register with 1.
- R6: When `frame_start` and `in_valid` are high in the same cycle, the reload happens first. That bit is therefore mixed with the first sequence bit of the new frame, which is 0.
- R7: The register advances only in cycles with `in_valid` high. Idle cycles leave the sequence where it was.
- R8: A second instance that receives the first instance's output, together with `frame_start` delayed by one cycle, reproduces the original data bits.
- R9: A `frame_start` pulse with `in_valid` low still reseeds. The next valid bit then uses the first sequence bit of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| in_valid | input | 1 | `in_bit` carries data this cycle |
| in_bit | input | 1 | Payload bit to scramble or descramble |
| out_valid | output | 1 | `out_bit` carries data this cycle |
| out_bit | output | 1 | Scrambled or descrambled bit |

## Verification
Two functions can land on the same clock edge: a frame reseed and the advance caused by an accepted bit. The bench raises `frame_start` together with `in_valid` at the start of a frame and again in the middle of a frame. In each case it expects the output bit to be mixed with the seed's first sequence bit, not with the bit the running register would have produced. The bench also places lone reseeds in idle cycles between data bits. A reference recurrence built in the bench judges every case over a sweep longer than one full sequence period. A chained receive instance must return the original bits each time.

// File: rtl/frame_scr_pkg.sv
package frame_scr_pkg;
  localparam int unsigned PN_W   = 10;
  localparam int unsigned TAP_HI = 10;
  localparam int unsigned TAP_LO = 3;
endpackage

// File: rtl/pn_source.sv
module pn_source #(
  parameter int unsigned W      = frame_scr_pkg::PN_W,
  parameter int unsigned TAP_HI = frame_scr_pkg::TAP_HI,
  parameter int unsigned TAP_LO = frame_scr_pkg::TAP_LO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic advance,
  output logic pn_bit
);
  localparam logic [W-1:0] SEED = '1;

  function automatic logic tap_mix(input logic [W-1:0] s);
    return s[TAP_HI-1] ^ s[TAP_LO-1];
  endfunction

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] s, input logic b);
    return {s[W-2:0], b};
  endfunction

  localparam logic FIRST_PN = tap_mix(SEED);

  logic [W-1:0] state_q;
  logic [W-1:0] base_state;
  logic [W-1:0] state_d;

  assign base_state = reseed ? SEED : state_q;
  assign pn_bit     = tap_mix(base_state);
  assign state_d    = advance ? shift_in(base_state, pn_bit) : base_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !reseed) |=> $stable(state_q));
  // R5
  reseed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed && !advance) |=> (state_q == SEED));
  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state_q[0] == $past(pn_bit)));
  // R6
  first_pn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |-> (pn_bit == FIRST_PN));
endmodule

// File: rtl/bit_mixer.sv
module bit_mixer (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic pn_bit,
  output logic out_valid,
  output logic out_bit
);
  function automatic logic mix(input logic d, input logic p);
    return d ^ p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_bit   <= in_valid ? mix(in_bit, pn_bit) : 1'b0;
    end
  end

  // R3
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_bit == ($past(in_bit) ^ $past(pn_bit))));
  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_bit);
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter int unsigned W      = frame_scr_pkg::PN_W,
  parameter int unsigned TAP_HI = frame_scr_pkg::TAP_HI,
  parameter int unsigned TAP_LO = frame_scr_pkg::TAP_LO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  logic pn_bit;

  pn_source #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_pn (
    .clk     (clk),
    .rst_n   (rst_n),
    .reseed  (frame_start),
    .advance (in_valid),
    .pn_bit  (pn_bit)
  );

  bit_mixer u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .pn_bit    (pn_bit),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!out_valid && !out_bit));
endmodule

// File: tb/test_frame_scrambler.sv
module test_frame_scrambler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, vin = 1'b0, bin = 1'b0;
  logic tx_v, tx_b, rx_v, rx_b, fs_d;
  int checks = 0, fails = 0;
  logic [9:0] hist;
  logic pend_v = 1'b0, pend_b = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fs_d <= 1'b0; else fs_d <= fs;

  frame_scrambler i_frame_scrambler (.clk(clk), .rst_n(rst_n), .frame_start(fs),
    .in_valid(vin), .in_bit(bin), .out_valid(tx_v), .out_bit(tx_b));
  frame_scrambler i_frame_scrambler_rx (.clk(clk), .rst_n(rst_n), .frame_start(fs_d),
    .in_valid(tx_v), .in_bit(tx_b), .out_valid(rx_v), .out_bit(rx_b));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: bit t of the sequence is bit t-10 XOR bit t-3; hist[k] holds bit t-1-k.
  task automatic send(input string req, input logic f, input logic v, input logic b);
    logic pn;
    fs = f; vin = v; bin = b;
    if (f) hist = '1;
    pn = hist[9] ^ hist[2];
    if (v) hist = {hist[8:0], pn};
    @(negedge clk);
    check("R3 out_valid", tx_v, v);
    check(req, tx_b, v ? (b ^ pn) : 1'b0);
    check("R8 rx_valid", rx_v, pend_v);
    if (pend_v) check("R8 rx_bit", rx_b, pend_b);
    pend_v = v; pend_b = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hist = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", tx_v, 1'b0);
    check("R1 reset out_bit", tx_b, 1'b0);
    send("R1 seed after reset", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) send("R2 data", 1'b0, 1'b1, i[0]);
    // R4: first 20 sequence bits after a reseed, data all zero
    send("R4 pn", 1'b1, 1'b1, 1'b0);
    for (int i = 1; i < 20; i++) send("R4 pn", 1'b0, 1'b1, 1'b0);
    // R7: idle gaps must not move the sequence
    for (int i = 0; i < 30; i++) send("R7 gaps", 1'b0, (i % 3) != 1, i[1] ^ i[2]);
    // R9 / R5: lone reseed in an idle cycle mid-frame
    send("R9 idle reseed", 1'b1, 1'b0, 1'b0);
    send("R9 first bit", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) send("R5 after reseed", 1'b0, 1'b1, 1'b1);
    // R6: reseed together with a valid bit mid-frame
    send("R6 same cycle", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) send("R6 follow", 1'b0, 1'b1, i[0]);
    // Sweep over more than one full period with mixed events
    for (int i = 0; i < 1200; i++)
      send("R2 sweep", (i % 337) == 0, (i % 5) != 4, i[0] ^ i[3] ^ ((i % 7) == 0));
    send("R8 flush", 1'b0, 1'b0, 1'b0);
    send("R8 flush", 1'b0, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule